// File: doc/BRIEF.md
# Fast page mode DRAM controller

This block sits between a synchronous host port and a 1M x 1 asynchronous dynamic RAM. The DRAM has ten multiplexed address pins, so the controller splits each 20-bit host address into two halves. The upper half is the row, latched by the row strobe. The lower half is the column, latched by the column strobe. Every phase of a cycle is timed by its own clock-count parameter. Each count is the matching nanosecond limit divided by the clock period and rounded up.

The host offers one request at a time with a valid/ready handshake. A request is a read, an early write or a read-modify-write. Setting the burst flag asks the controller to keep the row open, so that a following request to the same row runs as a fast-page column cycle. Each request ends with a one-cycle response pulse; for reads and read-modify-writes this pulse carries the bit read.

A refresh scheduler pulses a request line. The controller then runs a refresh with the column strobe ahead of the row strobe, but only once the row is closed. An open page is also closed before it reaches the longest legal row-strobe-low time.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset `ras_n`, `cas_n` and `we_n` are high, `rsp_valid` is low and `req_ready` is high while no refresh is requested.
- R2: The row address on `dram_a` is stable in the cycle before `ras_n` falls. It stays on the pins for at least `T_RAH` cycles of row-strobe-low before the column address replaces it.
- R3: `cas_n` falls no sooner than `T_RAH+T_CAD` cycles after `ras_n` falls. Read data is captured only after three limits have all elapsed: `T_RAC` cycles of row-strobe-low, `T_CAC` cycles of column-strobe-low and `T_AA` cycles of a stable column address. A read returns the stored bit in `rsp_rdata`.
- R4: `ras_n` stays high for at least `T_RP` cycles between low periods. Within an open page, `cas_n` stays high for at least `T_CP+T_CAD` cycles between column strobes.
- R5: An early write is a request with `req_write`=1 and `req_rmw`=0. For it, `we_n` is already low in the cycle before `cas_n` falls and stays low through the column strobe, and the bit on `dram_din` is stored.
- R6: A read-modify-write is a request with `req_write`=1 and `req_rmw`=1. In it, `we_n` falls only while `cas_n` is low, after the read bit has been captured. `rsp_rdata` returns the old bit and the new bit is stored.
- R7: Take a request accepted with `req_burst`=1, followed by a request to the same row (address bits 19:10). The second request runs without a new falling edge of `ras_n`.
- R8: The row is closed, with a new falling edge of `ras_n` before the next access, in two cases: the next request has a different row, or the previous request had `req_burst`=0.
- R9: A row-strobe-low period never lasts `MAX_RAS_CLK` cycles. A new page column is accepted only while fewer than `MAX_RAS_CLK-COL_GUARD` low cycles have elapsed.
- R10: In a refresh, `cas_n` falls at least `T_CSR` cycles before `ras_n` falls. `cas_n` stays low for at least `T_CHR` cycles after the fall of `ras_n`, and `we_n` stays high.
- R11: A refresh starts only from the closed-row state. While `refresh_req` is high or a refresh is pending, `req_ready` is low. A refresh requested during a burst closes the row after the current column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | 20 | Word address, row in bits 19:10, column in bits 9:0 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_rmw | input | 1 | With req_write, selects read-modify-write |
| req_wdata | input | 1 | Bit to write |
| req_burst | input | 1 | Keep the row open after this access |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 1 | Bit read (reads and read-modify-writes) |
| refresh_req | input | 1 | Refresh request pulse from the scheduler |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dram_a | output | 10 | Multiplexed address pins |
| dram_din | output | 1 | Data to the DRAM |
| dram_dout | input | 1 | Data from the DRAM |

## Verification
A refresh request and a host request can reach the controller in the same cycle. The bench raises both lines together in the closed-row state and checks that `req_ready` is low in that cycle. It then checks that the refresh count has already risen when the read response returns. The bench also raises a refresh right after a page column completes. It checks that the next same-row request pays a refresh plus a fresh row activation, and that the data stays correct.

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int ADDR_W      = 20,
  parameter int CNT_W       = 8,
  parameter int T_SETUP     = 1,
  parameter int T_RAH       = 2,
  parameter int T_CAD       = 2,
  parameter int T_RAC       = 9,
  parameter int T_CAC       = 3,
  parameter int T_AA        = 5,
  parameter int T_CASW      = 3,
  parameter int T_WP        = 2,
  parameter int T_CP        = 2,
  parameter int T_RP        = 7,
  parameter int T_CSR       = 2,
  parameter int T_CHR       = 5,
  parameter int T_REFW      = 4,
  parameter int MAX_RAS_CLK = 19000,
  parameter int COL_GUARD   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_rmw,
  input  logic              req_wdata,
  input  logic              req_burst,
  output logic              rsp_valid,
  output logic              rsp_rdata,
  input  logic              refresh_req,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W/2-1:0] dram_a,
  output logic              dram_din,
  input  logic              dram_dout
);
  localparam int AP_W = ADDR_W / 2;
  localparam int RW   = $clog2(MAX_RAS_CLK + 2);
  localparam logic [RW-1:0]    RAS_OPEN_LIM = RW'(MAX_RAS_CLK - COL_GUARD);
  localparam logic [RW-1:0]    RAC_L = RW'(T_RAC);
  localparam logic [CNT_W-1:0] CAC_L = CNT_W'(T_CAC);
  localparam logic [CNT_W-1:0] AA_L  = CNT_W'(T_AA);
  localparam logic [CNT_W-1:0] CASW_L = CNT_W'(T_CASW - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ACT, S_ROW, S_COLA, S_CAS, S_RMWW, S_CPRE, S_PAGE, S_PRE,
    S_CBR1, S_CBR2, S_CBR3
  } state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt, cas_cnt, col_cnt;
  logic [RW-1:0]     ras_cnt;
  logic [AP_W-1:0]   row_q, col_q;
  logic              wr_q, rmw_q, wd_q, burst_q, ref_pend;

  function automatic logic [CNT_W-1:0] ld(input int t);
    return CNT_W'(t - 1);
  endfunction

  wire [AP_W-1:0] row_in = req_addr[ADDR_W-1:AP_W];
  wire [AP_W-1:0] col_in = req_addr[AP_W-1:0];
  wire ref_any   = ref_pend | refresh_req;
  wire page_room = ras_cnt < RAS_OPEN_LIM;
  wire data_ok   = (ras_cnt >= RAC_L) && (cas_cnt >= CAC_L) && (col_cnt >= AA_L);
  wire cas_ok    = cas_cnt >= CASW_L;
  wire early_wr  = wr_q & ~rmw_q;
  wire col_run   = state inside {S_COLA, S_CAS, S_RMWW, S_CPRE};

  assign req_ready = !ref_any &&
                     ((state == S_IDLE) ||
                      (state == S_PAGE && page_room && row_in == row_q));
  wire take = req_valid & req_ready;

  assign ras_n = !(state inside {S_ROW, S_COLA, S_CAS, S_RMWW, S_CPRE, S_PAGE,
                                 S_CBR2, S_CBR3});
  assign cas_n = !(state inside {S_CAS, S_RMWW, S_CBR1, S_CBR2});
  assign we_n  = !((early_wr && state inside {S_COLA, S_CAS}) || state == S_RMWW);
  assign dram_a   = (state inside {S_COLA, S_CAS, S_RMWW, S_CPRE, S_PAGE}) ? col_q : row_q;
  assign dram_din = wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt <= '0; cas_cnt <= '0; col_cnt <= '0; ras_cnt <= '0;
      row_q <= '0; col_q <= '0;
      wr_q <= 1'b0; rmw_q <= 1'b0; wd_q <= 1'b0; burst_q <= 1'b0;
      ref_pend <= 1'b0; rsp_valid <= 1'b0; rsp_rdata <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (cnt != '0) cnt <= cnt - 1'b1;
      ras_cnt <= ras_n ? '0 : ((&ras_cnt) ? ras_cnt : ras_cnt + 1'b1);
      cas_cnt <= cas_n ? '0 : ((&cas_cnt) ? cas_cnt : cas_cnt + 1'b1);
      col_cnt <= !col_run ? '0 : ((&col_cnt) ? col_cnt : col_cnt + 1'b1);
      if (state == S_IDLE && ref_any) ref_pend <= 1'b0;
      else if (refresh_req)           ref_pend <= 1'b1;
      if (take) begin
        row_q   <= row_in;
        col_q   <= col_in;
        wr_q    <= req_write;
        rmw_q   <= req_write & req_rmw;
        wd_q    <= req_wdata;
        burst_q <= req_burst;
      end
      case (state)
        S_IDLE:
          if (ref_any) begin state <= S_CBR1; cnt <= ld(T_CSR); end
          else if (take) begin state <= S_ACT; cnt <= ld(T_SETUP); end
        S_ACT:  if (cnt == '0) begin state <= S_ROW;  cnt <= ld(T_RAH); end
        S_ROW:  if (cnt == '0) begin state <= S_COLA; cnt <= ld(T_CAD); end
        S_COLA: if (cnt == '0) state <= S_CAS;
        S_CAS:
          if (early_wr) begin
            if (cas_ok) begin rsp_valid <= 1'b1; state <= S_CPRE; cnt <= ld(T_CP); end
          end else if (cas_ok && data_ok) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= dram_dout;
            if (rmw_q) begin state <= S_RMWW; cnt <= ld(T_WP); end
            else       begin state <= S_CPRE; cnt <= ld(T_CP); end
          end
        S_RMWW: if (cnt == '0) begin state <= S_CPRE; cnt <= ld(T_CP); end
        S_CPRE:
          if (cnt == '0) begin
            if (burst_q && !ref_any && page_room) state <= S_PAGE;
            else begin state <= S_PRE; cnt <= ld(T_RP); end
          end
        S_PAGE:
          if (take) begin state <= S_COLA; cnt <= ld(T_CAD); end
          else if (ref_any || !page_room || (req_valid && row_in != row_q)) begin
            state <= S_PRE; cnt <= ld(T_RP);
          end
        S_PRE:  if (cnt == '0) state <= S_IDLE;
        S_CBR1: if (cnt == '0) begin state <= S_CBR2; cnt <= ld(T_CHR); end
        S_CBR2: if (cnt == '0) begin state <= S_CBR3; cnt <= ld(T_REFW); end
        S_CBR3: if (cnt == '0) begin state <= S_PRE;  cnt <= ld(T_RP); end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_row_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) && cas_n |-> $stable(dram_a));
  assert_row_to_cas_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) && !ras_n |-> ras_cnt >= RW'(T_RAH + T_CAD));
  assert_early_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) && !ras_n && !we_n |-> !$past(we_n));
  assert_rmw_we_late_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) && !cas_n |-> rsp_valid);
  assert_ras_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> ras_cnt < RW'(MAX_RAS_CLK));
  assert_cbr_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) && !cas_n |-> !$past(cas_n));
  assert_cbr_we_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n && (ras_n || state inside {S_CBR2, S_CBR3}) |-> we_n);
  assert_ref_blocks_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |-> !req_ready);
endmodule

// File: tb/fpm_dram_ctrl_bench.sv
`timescale 1ns/100ps
module fpm_dram_ctrl_bench;
  localparam int T_SETUP = 1, T_RAH = 2, T_CAD = 2, T_RAC = 9, T_CAC = 3, T_AA = 5;
  localparam int T_CASW = 3, T_WP = 2, T_CP = 2, T_RP = 7, T_CSR = 2, T_CHR = 5;
  localparam int T_REFW = 4, MAX_RAS = 80, GUARD = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_rmw = 0, req_wdata = 0, req_burst = 0;
  logic [19:0] req_addr = '0;
  logic refresh_req = 0, dram_dout = 0;
  logic req_ready, rsp_valid, rsp_rdata, ras_n, cas_n, we_n, dram_din;
  logic [9:0] dram_a;

  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  fpm_dram_ctrl #(
    .T_SETUP(T_SETUP), .T_RAH(T_RAH), .T_CAD(T_CAD), .T_RAC(T_RAC), .T_CAC(T_CAC),
    .T_AA(T_AA), .T_CASW(T_CASW), .T_WP(T_WP), .T_CP(T_CP), .T_RP(T_RP),
    .T_CSR(T_CSR), .T_CHR(T_CHR), .T_REFW(T_REFW), .MAX_RAS_CLK(MAX_RAS),
    .COL_GUARD(GUARD)
  ) u_fpm_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_rmw(req_rmw),
    .req_wdata(req_wdata), .req_burst(req_burst), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .refresh_req(refresh_req), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .dram_a(dram_a), .dram_din(dram_din), .dram_dout(dram_dout)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // DRAM model: stores bits, poisons output until all access limits elapse
  bit mem [int];
  int cyc = 0, ras_falls = 0, refreshes = 0;
  int t_rasf = -1000, t_rasr = -1000, t_casf = -1000, t_casr = -1000, t_colchg = -1000;
  logic prev_ras = 1, prev_cas = 1, prev_we = 1;
  logic [9:0] prev_a = '0, cur_row = '0, cur_col = '0;
  bit cbr = 0, chg_seen = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      int key;
      bit valid, bitv;
      cyc++;
      if (prev_ras && !ras_n) begin
        ras_falls++;
        t_rasf = cyc; chg_seen = 0; cbr = !cas_n;
        chk(cyc - t_rasr >= T_RP, "R4 ras precharge", cyc - t_rasr, T_RP);
        if (!cas_n) begin
          refreshes++;
          chk(cyc - t_casf >= T_CSR, "R10 cas lead", cyc - t_casf, T_CSR);
          chk(we_n == 1'b1, "R10 we high", int'(we_n), 1);
        end else begin
          cur_row = dram_a;
          chk(dram_a == prev_a, "R2 row setup", int'(dram_a), int'(prev_a));
        end
      end
      if (!prev_ras && ras_n) begin
        t_rasr = cyc;
        chk(cyc - t_rasf < MAX_RAS, "R9 ras low length", cyc - t_rasf, MAX_RAS);
      end
      if (!ras_n && !prev_ras && !cbr && dram_a != prev_a) begin
        t_colchg = cyc;
        if (!chg_seen) begin
          chg_seen = 1;
          chk(cyc - t_rasf >= T_RAH, "R2 row hold", cyc - t_rasf, T_RAH);
        end
      end
      if (prev_cas && !cas_n) begin
        t_casf = cyc;
        if (!ras_n) begin
          cur_col = dram_a;
          chk(cyc - t_rasf >= T_RAH + T_CAD, "R3 ras to cas", cyc - t_rasf, T_RAH + T_CAD);
          if (t_casr > t_rasf)
            chk(cyc - t_casr >= T_CP + T_CAD, "R4 page cas precharge", cyc - t_casr, T_CP + T_CAD);
          if (!we_n) begin
            chk(!prev_we, "R5 we before cas", int'(prev_we), 0);
            mem[int'({cur_row, cur_col})] = dram_din;
          end
        end
      end
      if (!prev_cas && cas_n) begin
        t_casr = cyc;
        if (!ras_n && cbr) chk(cyc - t_rasf >= T_CHR, "R10 cas hold", cyc - t_rasf, T_CHR);
      end
      key = int'({cur_row, cur_col});
      if (!ras_n && !cas_n && !prev_cas && prev_we && !we_n) begin
        chk(cyc - t_rasf > T_RAC && cyc - t_casf > T_CAC, "R6 we after data",
            cyc - t_casf, T_CAC + 1);
        mem[key] = dram_din;
      end
      valid = !ras_n && !cas_n && !cbr && (cyc - t_rasf >= T_RAC) &&
              (cyc - t_casf >= T_CAC) && (cyc - t_colchg >= T_AA);
      bitv = mem.exists(key) ? mem[key] : 1'b0;
      dram_dout = valid ? bitv : ~bitv;
      prev_ras = ras_n; prev_cas = cas_n; prev_we = we_n; prev_a = dram_a;
    end
  end

  task automatic do_req(input logic [1:0] op, input logic burst, input logic [19:0] addr,
                        input logic wd, output logic rd);
    @(negedge clk);
    req_valid = 1; req_addr = addr; req_write = (op != 0); req_rmw = (op == 2);
    req_wdata = wd; req_burst = burst;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
  endtask

  // op[24:23] 0=read 1=write 2=rmw, burst[22], addr[21:2], wdata[1], expected read[0]
  localparam logic [24:0] VEC [14] = '{
    {2'd1, 1'b0, 20'h0A005, 1'b1, 1'b0},
    {2'd1, 1'b1, 20'h0A006, 1'b0, 1'b0},
    {2'd1, 1'b1, 20'h0A007, 1'b1, 1'b0},
    {2'd1, 1'b0, 20'h0A008, 1'b1, 1'b0},
    {2'd0, 1'b1, 20'h0A005, 1'b0, 1'b1},
    {2'd0, 1'b1, 20'h0A006, 1'b0, 1'b0},
    {2'd0, 1'b1, 20'h0A007, 1'b0, 1'b1},
    {2'd0, 1'b0, 20'h0A008, 1'b0, 1'b1},
    {2'd2, 1'b0, 20'h0A006, 1'b1, 1'b0},
    {2'd0, 1'b0, 20'h0A006, 1'b0, 1'b1},
    {2'd2, 1'b1, 20'h3FF00, 1'b1, 1'b0},
    {2'd2, 1'b1, 20'h3FF00, 1'b0, 1'b1},
    {2'd0, 1'b0, 20'h3FF00, 1'b0, 1'b0},
    {2'd0, 1'b0, 20'h155AA, 1'b0, 1'b0}
  };

  initial begin
    int base, rbase;
    logic rd;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(ras_n && cas_n && we_n, "R1 strobes idle", int'({ras_n, cas_n, we_n}), 7);
    chk(!rsp_valid, "R1 no response", int'(rsp_valid), 0);
    chk(req_ready, "R1 ready", int'(req_ready), 1);

    base = 0;
    for (int i = 0; i < 14; i++) begin
      logic [24:0] v;
      v = VEC[i];
      if (i == 4) base = ras_falls;
      do_req(v[24:23], v[22], v[21:2], v[1], rd);
      if (v[24:23] == 2'd0) chk(rd == v[0], "R3 read data", int'(rd), int'(v[0]));
      if (v[24:23] == 2'd2) chk(rd == v[0], "R6 rmw old data", int'(rd), int'(v[0]));
      if (i == 7) chk(ras_falls - base == 1, "R7 page reads share row", ras_falls - base, 1);
      if (i == 9) chk(rd == 1'b1, "R6 rmw new data", int'(rd), 1);
      if (i == 3) begin
        do_req(2'd0, 1'b0, 20'h0A005, 1'b0, rd);
        chk(rd == 1'b1, "R5 early write stored", int'(rd), 1);
      end
    end

    // R8: row miss after burst closes the row
    base = ras_falls;
    do_req(2'd0, 1'b1, 20'h0A005, 1'b0, rd);
    do_req(2'd0, 1'b0, 20'h3FF00, 1'b0, rd);
    chk(ras_falls - base == 2, "R8 row miss reopens", ras_falls - base, 2);
    chk(rd == 1'b0, "R8 row miss data", int'(rd), 0);
    base = ras_falls;
    do_req(2'd0, 1'b0, 20'h0A007, 1'b0, rd);
    do_req(2'd0, 1'b0, 20'h0A008, 1'b0, rd);
    chk(ras_falls - base == 2, "R8 no burst closes", ras_falls - base, 2);

    // R10: idle refresh
    base = refreshes;
    @(negedge clk); refresh_req = 1;
    @(negedge clk); refresh_req = 0;
    repeat (30) @(negedge clk);
    chk(refreshes - base == 1, "R10 refresh ran", refreshes - base, 1);

    // R11: refresh and host request in the same cycle
    base = refreshes;
    @(negedge clk);
    refresh_req = 1; req_valid = 1; req_addr = 20'h0A005;
    req_write = 0; req_rmw = 0; req_burst = 0;
    #1;
    chk(!req_ready, "R11 ready low on refresh", int'(req_ready), 0);
    @(negedge clk); refresh_req = 0; #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk); req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    chk(refreshes - base == 1, "R11 refresh first", refreshes - base, 1);
    chk(rsp_rdata == 1'b1, "R11 read after refresh", int'(rsp_rdata), 1);

    // R11: refresh during a burst ends the page
    base = ras_falls; rbase = refreshes;
    do_req(2'd0, 1'b1, 20'h0A006, 1'b0, rd);
    refresh_req = 1;
    @(negedge clk); refresh_req = 0;
    do_req(2'd0, 1'b0, 20'h0A007, 1'b0, rd);
    chk(refreshes - rbase == 1, "R11 burst refresh", refreshes - rbase, 1);
    chk(ras_falls - base == 3, "R11 burst closed", ras_falls - base, 3);
    chk(rd == 1'b1, "R11 data after burst refresh", int'(rd), 1);

    // R9: long page burst must be split
    do_req(2'd1, 1'b0, 20'h2F003, 1'b1, rd);
    base = ras_falls;
    for (int c = 0; c < 16; c++) begin
      do_req(2'd0, (c != 15), {10'h0BC, 10'(c)}, 1'b0, rd);
      chk(rd == (c == 3), "R9 long burst data", int'(rd), int'(c == 3));
    end
    chk(ras_falls - base >= 2, "R9 row reopened", ras_falls - base, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule